// File: doc/BRIEF.md
# Writeback-to-Execute Operand Bypass

This block supplies both source operands to the execute stage of a three-stage, single-issue, in-order integer pipeline (fetch/decode, execute, writeback). It holds the architectural register file and reads it at the two source indices of the instruction in execute. It also compares each of those indices with the destination index of the instruction in writeback. On a match it sends the writeback value to the operand instead of the stale register-file word. The writeback value is either the ALU result or the word just read from data memory, and a load flag chooses between them.

Load data arrives from memory during writeback and goes to execute through the same single mux. A dependent instruction directly behind a load therefore runs with no bubble, and the block never requests a stall. The register file commits the writeback value on the clock edge that ends writeback.

Because issue is single and in order, write-after-write and write-after-read orderings cannot occur. Only the read-after-write case between writeback and execute needs handling. The ALU, the memories and the decoder lie outside the block and are seen only as plain signals.

Top module: `wb_ex_bypass`

## Requirements
- R1: With no qualifying writeback match, each operand equals the register-file word at its source index. The matching flag for that operand is 0.
- R2: Operand 1 is forwarded when the writeback slot is live, writes a register, has a non-zero destination, and that destination equals the source-1 index. If the writeback instruction is not a load, the forwarded value is the ALU result and ex_fwd1_o is 1.
- R3: When the writeback instruction is a load (wb_is_load_i=1), a forwarded operand takes the data-memory word rather than the ALU result. This happens with no stall.
- R4: Operand 2 follows the same rule using its own index, independently of operand 1. Both operands may be forwarded in the same cycle.
- R5: Index 0 always reads zero. A writeback to destination 0 neither forwards nor changes any register.
- R6: When wb_we_i=0 there is no forwarding and no register-file write.
- R7: A killed writeback slot (wb_valid_i=0) neither forwards nor writes, whatever its other fields hold.
- R8: A live, writing writeback with a non-zero destination stores its selected value on the clock edge. From the next cycle on, that value is read from the register file at that index.
- R9: After the active-low asynchronous reset, every register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ex_rs1_idx_i | input | 5 | Execute source-1 register index |
| ex_rs2_idx_i | input | 5 | Execute source-2 register index |
| wb_valid_i | input | 1 | Writeback slot holds a live (not killed) instruction |
| wb_we_i | input | 1 | Writeback instruction writes a register |
| wb_rd_idx_i | input | 5 | Writeback destination index |
| wb_is_load_i | input | 1 | Writeback instruction is a load |
| wb_alu_res_i | input | 32 | ALU result carried in writeback |
| wb_mem_rdata_i | input | 32 | Data-memory word read in writeback |
| ex_op1_o | output | 32 | Source operand 1 for execute |
| ex_op2_o | output | 32 | Source operand 2 for execute |
| ex_fwd1_o | output | 1 | Operand 1 taken from writeback |
| ex_fwd2_o | output | 1 | Operand 2 taken from writeback |

## Verification
The properties assume that every writeback input is a settled, known value at each clock edge, and that the indices stay within the 32-entry file. The commit property also assumes a reset pulse before the first check. The bench changes inputs only on the falling edge and releases reset before any writeback is marked live. It then sends index sequences that deliberately revisit registers the earlier cycles wrote. The operands are therefore compared against a known register image and never against unknown contents.

// File: rtl/bypass_pkg.sv
package bypass_pkg;
  parameter int unsigned XLEN      = 32;
  parameter int unsigned REG_IDX_W = 5;
  parameter int unsigned NUM_SRC   = 2;
  localparam int unsigned NUM_REGS = 1 << REG_IDX_W;

  typedef logic [XLEN-1:0]      word_t;
  typedef logic [REG_IDX_W-1:0] ridx_t;

  typedef enum logic {
    OP_FROM_RF = 1'b0,
    OP_FROM_WB = 1'b1
  } op_src_e;
endpackage

// File: rtl/bypass_wb_sel.sv
module bypass_wb_sel #(
  parameter int unsigned XLEN = 32
) (
  input  logic            is_load_i,
  input  logic [XLEN-1:0] alu_res_i,
  input  logic [XLEN-1:0] mem_rdata_i,
  output logic [XLEN-1:0] wb_value_o
);
  // single mux: load data and ALU result share one forward path
  always_comb begin
    wb_value_o = is_load_i ? mem_rdata_i : alu_res_i;
  end
endmodule

// File: rtl/bypass_regfile.sv
module bypass_regfile #(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned IDX_W  = 5,
  parameter int unsigned NUM_RD = 2
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           we_i,
  input  logic [IDX_W-1:0]               waddr_i,
  input  logic [XLEN-1:0]                wdata_i,
  input  logic [NUM_RD-1:0][IDX_W-1:0]   raddr_i,
  output logic [NUM_RD-1:0][XLEN-1:0]    rdata_o
);
  localparam int unsigned NREGS = 1 << IDX_W;

  logic [XLEN-1:0] rf_word [NREGS];

  // entry 0 is hardwired to zero
  assign rf_word[0] = '0;

  for (genvar g = 1; g < NREGS; g++) begin : g_reg
    logic [XLEN-1:0] q;
    logic            sel;
    assign sel = we_i && (waddr_i == IDX_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  q <= '0;
      else if (sel) q <= wdata_i;
    end
    assign rf_word[g] = q;
  end

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    assign rdata_o[p] = rf_word[raddr_i[p]];
  end
endmodule

// File: rtl/bypass_match.sv
module bypass_match #(
  parameter int unsigned IDX_W = 5
) (
  input  logic             commit_i,
  input  logic [IDX_W-1:0] wb_rd_i,
  input  logic [IDX_W-1:0] src_idx_i,
  output bypass_pkg::op_src_e src_o
);
  import bypass_pkg::*;
  always_comb begin
    src_o = (commit_i && (wb_rd_i == src_idx_i)) ? OP_FROM_WB : OP_FROM_RF;
  end
endmodule

// File: rtl/wb_ex_bypass.sv
module wb_ex_bypass #(
  parameter int unsigned XLEN      = bypass_pkg::XLEN,
  parameter int unsigned REG_IDX_W = bypass_pkg::REG_IDX_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [REG_IDX_W-1:0] ex_rs1_idx_i,
  input  logic [REG_IDX_W-1:0] ex_rs2_idx_i,
  input  logic                 wb_valid_i,
  input  logic                 wb_we_i,
  input  logic [REG_IDX_W-1:0] wb_rd_idx_i,
  input  logic                 wb_is_load_i,
  input  logic [XLEN-1:0]      wb_alu_res_i,
  input  logic [XLEN-1:0]      wb_mem_rdata_i,
  output logic [XLEN-1:0]      ex_op1_o,
  output logic [XLEN-1:0]      ex_op2_o,
  output logic                 ex_fwd1_o,
  output logic                 ex_fwd2_o
);
  import bypass_pkg::*;
  localparam int unsigned NSRC = NUM_SRC;

  logic                              wb_commit;
  logic [XLEN-1:0]                   wb_value;
  logic [NSRC-1:0][REG_IDX_W-1:0]    src_idx;
  logic [NSRC-1:0][XLEN-1:0]         rf_rdata;
  logic [NSRC-1:0][XLEN-1:0]         op_val;
  logic [NSRC-1:0]                   op_fwd;

  // killed slots, non-writers and x0 destinations are excluded once here
  assign wb_commit  = wb_valid_i && wb_we_i && (wb_rd_idx_i != '0);
  assign src_idx[0] = ex_rs1_idx_i;
  assign src_idx[1] = ex_rs2_idx_i;

  bypass_wb_sel #(.XLEN(XLEN)) u_wb_sel (
    .is_load_i   (wb_is_load_i),
    .alu_res_i   (wb_alu_res_i),
    .mem_rdata_i (wb_mem_rdata_i),
    .wb_value_o  (wb_value)
  );

  bypass_regfile #(.XLEN(XLEN), .IDX_W(REG_IDX_W), .NUM_RD(NSRC)) u_rf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wb_commit),
    .waddr_i (wb_rd_idx_i),
    .wdata_i (wb_value),
    .raddr_i (src_idx),
    .rdata_o (rf_rdata)
  );

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    op_src_e sel;
    bypass_match #(.IDX_W(REG_IDX_W)) u_match (
      .commit_i  (wb_commit),
      .wb_rd_i   (wb_rd_idx_i),
      .src_idx_i (src_idx[s]),
      .src_o     (sel)
    );
    assign op_fwd[s] = (sel == OP_FROM_WB);
    assign op_val[s] = op_fwd[s] ? wb_value : rf_rdata[s];
  end

  assign ex_op1_o  = op_val[0];
  assign ex_op2_o  = op_val[1];
  assign ex_fwd1_o = op_fwd[0];
  assign ex_fwd2_o = op_fwd[1];
endmodule

// File: rtl/wb_ex_bypass_chk.sv
module wb_ex_bypass_chk #(
  parameter int unsigned XLEN      = 32,
  parameter int unsigned REG_IDX_W = 5
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [REG_IDX_W-1:0] ex_rs1_idx_i,
  input logic [REG_IDX_W-1:0] ex_rs2_idx_i,
  input logic                 wb_valid_i,
  input logic                 wb_we_i,
  input logic [REG_IDX_W-1:0] wb_rd_idx_i,
  input logic                 wb_is_load_i,
  input logic [XLEN-1:0]      wb_alu_res_i,
  input logic [XLEN-1:0]      wb_mem_rdata_i,
  input logic [XLEN-1:0]      ex_op1_o,
  input logic [XLEN-1:0]      ex_op2_o,
  input logic                 ex_fwd1_o,
  input logic                 ex_fwd2_o
);
  logic [XLEN-1:0] wb_pick;
  logic            live_wr;
  assign wb_pick = wb_is_load_i ? wb_mem_rdata_i : wb_alu_res_i;
  assign live_wr = wb_valid_i && wb_we_i && (wb_rd_idx_i != '0);

  p_fwd_alu_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ex_fwd1_o && !wb_is_load_i) |-> (ex_op1_o == wb_alu_res_i));

  p_fwd_hit_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_wr && (wb_rd_idx_i == ex_rs1_idx_i)) |-> ex_fwd1_o);

  p_fwd_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ex_fwd1_o && wb_is_load_i) |-> (ex_op1_o == wb_mem_rdata_i));

  p_src2_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ex_fwd2_o |-> (ex_op2_o == wb_pick && ex_rs2_idx_i == wb_rd_idx_i));

  p_x0_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ex_rs1_idx_i == '0) |-> (ex_op1_o == '0 && !ex_fwd1_o));

  p_no_we_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wb_we_i |-> (!ex_fwd1_o && !ex_fwd2_o));

  p_killed_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wb_valid_i |-> (!ex_fwd1_o && !ex_fwd2_o));

  p_commit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(live_wr) && !ex_fwd1_o && (ex_rs1_idx_i == $past(wb_rd_idx_i)))
      |-> (ex_op1_o == $past(wb_pick)));
endmodule

bind wb_ex_bypass wb_ex_bypass_chk #(.XLEN(XLEN), .REG_IDX_W(REG_IDX_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .ex_rs1_idx_i   (ex_rs1_idx_i),
  .ex_rs2_idx_i   (ex_rs2_idx_i),
  .wb_valid_i     (wb_valid_i),
  .wb_we_i        (wb_we_i),
  .wb_rd_idx_i    (wb_rd_idx_i),
  .wb_is_load_i   (wb_is_load_i),
  .wb_alu_res_i   (wb_alu_res_i),
  .wb_mem_rdata_i (wb_mem_rdata_i),
  .ex_op1_o       (ex_op1_o),
  .ex_op2_o       (ex_op2_o),
  .ex_fwd1_o      (ex_fwd1_o),
  .ex_fwd2_o      (ex_fwd2_o)
);

// File: tb/sim_wb_ex_bypass.sv
`timescale 1ns/1ps
module sim_wb_ex_bypass;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  rs1, rs2, rd;
  logic        valid, we, ld;
  logic [31:0] alu, mem;
  logic [31:0] op1, op2;
  logic        f1, f2;

  always #5 clk = ~clk;

  wb_ex_bypass u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .ex_rs1_idx_i(rs1), .ex_rs2_idx_i(rs2),
    .wb_valid_i(valid), .wb_we_i(we), .wb_rd_idx_i(rd), .wb_is_load_i(ld),
    .wb_alu_res_i(alu), .wb_mem_rdata_i(mem),
    .ex_op1_o(op1), .ex_op2_o(op2), .ex_fwd1_o(f1), .ex_fwd2_o(f2)
  );

  typedef struct {
    logic [31:0] e1;
    logic [31:0] e2;
    logic        ef1;
    logic        ef2;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  logic [31:0] mdl [32];
  int          checks = 0;
  int          errors = 0;
  bit          done = 0;
  event        ev_drv;

  // driver: sets inputs on the falling edge, predicts, then updates the model
  task automatic drive(input logic [4:0] a, input logic [4:0] b, input logic v,
                       input logic w, input logic [4:0] d, input logic l,
                       input logic [31:0] ar, input logic [31:0] mr, input string tag);
    exp_t        e;
    logic        cm;
    logic [31:0] wv;
    @(negedge clk);
    rs1 = a; rs2 = b; valid = v; we = w; rd = d; ld = l; alu = ar; mem = mr;
    cm    = v && w && (d != 5'd0);
    wv    = l ? mr : ar;
    e.ef1 = cm && (d == a);
    e.ef2 = cm && (d == b);
    e.e1  = e.ef1 ? wv : mdl[a];
    e.e2  = e.ef2 ? wv : mdl[b];
    e.tag = tag;
    sb.push_back(e);
    -> ev_drv;
    if (cm) mdl[d] = wv;
  endtask

  // monitor: samples 2 ns after inputs settle, well before the next rising edge
  initial begin
    forever begin
      @(ev_drv);
      #2;
      if (sb.size() != 0) begin
        exp_t e;
        bit   bad;
        e = sb.pop_front();
        bad = 0;
        checks++;
        if (op1 !== e.e1) begin
          $display("FAIL %s op1 actual=%h expected=%h", e.tag, op1, e.e1); bad = 1;
        end
        if (op2 !== e.e2) begin
          $display("FAIL %s op2 actual=%h expected=%h", e.tag, op2, e.e2); bad = 1;
        end
        if (f1 !== e.ef1) begin
          $display("FAIL %s fwd1 actual=%b expected=%b", e.tag, f1, e.ef1); bad = 1;
        end
        if (f2 !== e.ef2) begin
          $display("FAIL %s fwd2 actual=%b expected=%b", e.tag, f2, e.ef2); bad = 1;
        end
        if (bad) errors++;
      end
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) mdl[i] = 32'h0;
    rs1 = 0; rs2 = 0; valid = 0; we = 0; rd = 0; ld = 0; alu = 0; mem = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R9: reset state, killed slot
    drive(5'd7, 5'd31, 0, 0, 5'd0, 0, 32'h0, 32'h0, "R9");
    drive(5'd1, 5'd16, 0, 0, 5'd0, 0, 32'h0, 32'h0, "R9");

    // R2: ALU forward to operand 1, also writes x5
    drive(5'd5, 5'd6, 1, 1, 5'd5, 0, 32'h1234_5678, 32'hDEAD_BEEF, "R2");
    // R8: x5 now from register file, no forward
    drive(5'd5, 5'd5, 0, 0, 5'd0, 0, 32'h0, 32'h0, "R8");

    // R3: load forward back-to-back to operand 1
    drive(5'd9, 5'd5, 1, 1, 5'd9, 1, 32'hAAAA_0000, 32'hCAFE_F00D, "R3");
    drive(5'd9, 5'd0, 0, 1, 5'd9, 0, 32'h0, 32'h0, "R8");

    // R4: operand 2 only, then both operands on same index
    drive(5'd5, 5'd12, 1, 1, 5'd12, 0, 32'h0000_0C0C, 32'h0, "R4");
    drive(5'd14, 5'd14, 1, 1, 5'd14, 1, 32'h0, 32'h7777_1111, "R4");
    drive(5'd12, 5'd14, 0, 0, 5'd0, 0, 32'h0, 32'h0, "R8");

    // R5: destination x0 neither forwards nor writes
    drive(5'd0, 5'd0, 1, 1, 5'd0, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R5");
    drive(5'd0, 5'd5, 0, 0, 5'd0, 0, 32'h0, 32'h0, "R5");

    // R6: no write enable: no forward, register keeps old value
    drive(5'd5, 5'd9, 1, 0, 5'd5, 0, 32'h5555_5555, 32'h0, "R6");
    drive(5'd5, 5'd9, 0, 0, 5'd0, 0, 32'h0, 32'h0, "R6");

    // R7: killed slot with matching fields: no forward, no write
    drive(5'd9, 5'd12, 0, 1, 5'd9, 1, 32'h0, 32'h9999_9999, "R7");
    drive(5'd9, 5'd12, 0, 0, 5'd0, 0, 32'h0, 32'h0, "R7");

    // R1: non-matching writeback, operands from register file
    drive(5'd5, 5'd14, 1, 1, 5'd20, 0, 32'h2020_2020, 32'h0, "R1");
    drive(5'd20, 5'd3, 0, 0, 5'd0, 0, 32'h0, 32'h0, "R8");

    // R2/R8: overwrite chain on one register, each forwarded then committed
    for (int k = 0; k < 8; k++) begin
      drive(5'd31, 5'd20, 1, 1, 5'd31, k[0], 32'h100 + k, 32'h200 + k, "R2");
    end
    drive(5'd31, 5'd31, 0, 0, 5'd0, 0, 32'h0, 32'h0, "R8");

    // R4: sweep operand-2 index against writebacks
    for (int k = 1; k < 32; k++) begin
      drive(5'd0, 5'(k), 1, 1, 5'(k), 1, 32'h0, 32'hB000_0000 + k, "R4");
    end
    for (int k = 0; k < 32; k++) begin
      drive(5'(k), 5'(31 - k), 0, 0, 5'd0, 0, 32'h0, 32'h0, "R8");
    end

    @(negedge clk);
    #3;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule